// File: doc/BRIEF.md
# Reservation-Station Fan-In/Fan-Out Router

This block connects a group of function-unit reservation stations to one shared, externally built computation pipeline. On the entry side, any station that is not busy may raise a request with an operand word and a small per-lane predicate mask. A round-robin arbiter accepts at most one request per cycle. The accepted entry enters an issue register that feeds the pipeline. The entry carries the winning station's one-hot tag. Its mask is placed in that station's own field of a concatenated mask vector, so no lane bits are lost when several stations share the path.

On the exit side, results come back tagged. The router routes each result by its tag alone and never by arrival order. For the matching station it latches the result word and that station's mask field, and pulses a one-cycle done strobe. A station is busy from acceptance until its result is routed or it is cancelled. A cancel request drives a global cancel vector that the pipeline uses to drop the tag in every stage at once. The station can then be issued again on the next cycle without waiting for the old entry to drain. When all stations are busy, issue stalls.

Top module: `fu_fanio_router`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o`, `pipe_valid_o` and `done_o` are all zero.
- R2: In a cycle where at least one requesting station is idle, exactly one `req_grant_o` bit rises in that same cycle. After the next clock edge, `pipe_valid_o` is 1, `pipe_tag_o` equals the grant (bit k means station k) and `pipe_data_o` holds that station's operand.
- R3: Arbitration is round-robin. After station k is granted, the search for the next grant starts at station k+1, wrapping from N-1 to 0. The first search after reset starts at station 0.
- R4: `pipe_mask_o` is the concatenation of per-station fields of width MW, with station k at bits [k*MW +: MW]. The winner's mask appears in its own field and every other field is zero.
- R5: A granted station's `busy_o` bit is 1 from the edge after the grant until a routed result or a cancel clears it. A request from a busy station is not granted.
- R6: When every station is busy, no grant is given.
- R7: A `ret_tag_i` bit k for a busy, non-cancelled station causes the following results after the next edge. `done_o[k]` is high for exactly one cycle. Field k of `res_data_o` (RESW wide) holds `ret_data_i`. Field k of `res_mask_o` holds field k of `ret_mask_i`. `busy_o[k]` clears.
- R8: A return with a zero tag, or with a tag whose station is idle, produces no done pulse and leaves the busy flags unchanged.
- R9: `cancel_i[k]` for a busy station sets `pipe_cancel_o[k]` in the same cycle and clears `busy_o[k]` at the next edge. The station may be granted on the following cycle.
- R10: If a station is cancelled in the same cycle its result returns, the cancel wins. No done pulse is given and busy clears.
- R11: `cancel_i[k]` for an idle station does not set `pipe_cancel_o[k]` and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | N_RS | Issue request, one bit per station |
| req_data_i | input | N_RS*OPW | Operand word per station, station k at [k*OPW +: OPW] |
| req_mask_i | input | N_RS*MW | Predicate mask per station |
| req_grant_o | output | N_RS | One-hot acceptance for this cycle |
| busy_o | output | N_RS | Station busy flags |
| cancel_i | input | N_RS | Cancel request per station |
| pipe_valid_o | output | 1 | Issue register holds a new entry |
| pipe_tag_o | output | N_RS | One-hot tag of the issued entry |
| pipe_data_o | output | OPW | Operand of the issued entry |
| pipe_mask_o | output | N_RS*MW | Concatenated predicate mask |
| pipe_cancel_o | output | N_RS | Global cancel vector to all pipeline stages |
| ret_tag_i | input | N_RS | Tag of the returning result |
| ret_data_i | input | RESW | Returning result word |
| ret_mask_i | input | N_RS*MW | Returning concatenated mask |
| done_o | output | N_RS | One-cycle result strobe per station |
| res_data_o | output | N_RS*RESW | Latched result per station |
| res_mask_o | output | N_RS*MW | Latched mask field per station |

## Verification
The overlap of most interest is a cancel and a result return that target the same station in one cycle. The other is a cancel of one station beside a grant or return for another. The table drives a cancel on every station together with a return on a busy one. It then judges the next-edge state: no done strobe, all busy flags clear, and every cancel bit seen on the global vector in the same cycle. A second run closes the loop through a delay-line model of the pipeline. It cancels a station while its entry is in flight and re-issues the station at once. It expects exactly one done strobe for that station, carrying the re-issued operand's result.

// File: rtl/fanio_pkg.sv
package fanio_pkg;
    localparam int unsigned DEF_STATIONS = 3;
    localparam int unsigned DEF_OPW      = 16;
    localparam int unsigned DEF_RESW     = 16;
    localparam int unsigned DEF_MASKW    = 2;

    // circular increment used by the round-robin pointer
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/fanio_rr_pick.sv
module fanio_rr_pick #(
    parameter int unsigned N  = 3,
    localparam int unsigned PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig_i,
    input  logic [PW-1:0] ptr_i,
    output logic [N-1:0]  grant_o,
    output logic [PW-1:0] win_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        win_o   = '0;
        for (int unsigned off = 0; off < N; off++) begin
            int unsigned idx;
            idx = (32'(ptr_i) + off) % N;
            if (!found && elig_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                win_o        = PW'(idx);
            end
        end
    end
endmodule

// File: rtl/fanio_fanin.sv
module fanio_fanin #(
    parameter int unsigned N   = 3,
    parameter int unsigned OPW = 16,
    parameter int unsigned MW  = 2
) (
    input  logic [N-1:0]     grant_i,
    input  logic [N*OPW-1:0] data_i,
    input  logic [N*MW-1:0]  mask_i,
    output logic [OPW-1:0]   data_o,
    output logic [N*MW-1:0]  mask_o
);
    // each station keeps its own mask field; only the winner's is non-zero
    for (genvar k = 0; k < N; k++) begin : g_field
        assign mask_o[k*MW +: MW] = grant_i[k] ? mask_i[k*MW +: MW] : '0;
    end

    always_comb begin
        data_o = '0;
        for (int unsigned k = 0; k < N; k++) begin
            if (grant_i[k]) data_o = data_o | data_i[k*OPW +: OPW];
        end
    end
endmodule

// File: rtl/fanio_fanout.sv
module fanio_fanout #(
    parameter int unsigned N    = 3,
    parameter int unsigned RESW = 16,
    parameter int unsigned MW   = 2
) (
    input  logic [N-1:0]      hit_i,
    input  logic [RESW-1:0]   ret_data_i,
    input  logic [N*MW-1:0]   ret_mask_i,
    input  logic [N*RESW-1:0] cur_data_i,
    input  logic [N*MW-1:0]   cur_mask_i,
    output logic [N*RESW-1:0] nxt_data_o,
    output logic [N*MW-1:0]   nxt_mask_o
);
    for (genvar k = 0; k < N; k++) begin : g_latch
        assign nxt_data_o[k*RESW +: RESW] = hit_i[k] ? ret_data_i : cur_data_i[k*RESW +: RESW];
        assign nxt_mask_o[k*MW +: MW]     = hit_i[k] ? ret_mask_i[k*MW +: MW] : cur_mask_i[k*MW +: MW];
    end
endmodule

// File: rtl/fu_fanio_router.sv
module fu_fanio_router #(
    parameter int unsigned N_RS = fanio_pkg::DEF_STATIONS,
    parameter int unsigned OPW  = fanio_pkg::DEF_OPW,
    parameter int unsigned RESW = fanio_pkg::DEF_RESW,
    parameter int unsigned MW   = fanio_pkg::DEF_MASKW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_RS-1:0]      req_valid_i,
    input  logic [N_RS*OPW-1:0]  req_data_i,
    input  logic [N_RS*MW-1:0]   req_mask_i,
    output logic [N_RS-1:0]      req_grant_o,
    output logic [N_RS-1:0]      busy_o,
    input  logic [N_RS-1:0]      cancel_i,
    output logic                 pipe_valid_o,
    output logic [N_RS-1:0]      pipe_tag_o,
    output logic [OPW-1:0]       pipe_data_o,
    output logic [N_RS*MW-1:0]   pipe_mask_o,
    output logic [N_RS-1:0]      pipe_cancel_o,
    input  logic [N_RS-1:0]      ret_tag_i,
    input  logic [RESW-1:0]      ret_data_i,
    input  logic [N_RS*MW-1:0]   ret_mask_i,
    output logic [N_RS-1:0]      done_o,
    output logic [N_RS*RESW-1:0] res_data_o,
    output logic [N_RS*MW-1:0]   res_mask_o
);
    localparam int unsigned PW = (N_RS > 1) ? $clog2(N_RS) : 1;

    typedef struct packed {
        logic [N_RS-1:0]      busy;
        logic [PW-1:0]        rr;
        logic                 pvalid;
        logic [N_RS-1:0]      ptag;
        logic [OPW-1:0]       pdata;
        logic [N_RS*MW-1:0]   pmask;
        logic [N_RS-1:0]      done;
        logic [N_RS*RESW-1:0] rdata;
        logic [N_RS*MW-1:0]   rmask;
    } state_t;

    state_t st_q, st_d;

    logic [N_RS-1:0]      elig, grant, hit, kill;
    logic [PW-1:0]        win;
    logic [OPW-1:0]       sel_data;
    logic [N_RS*MW-1:0]   sel_mask;
    logic [N_RS*RESW-1:0] nxt_rdata;
    logic [N_RS*MW-1:0]   nxt_rmask;

    assign elig = req_valid_i & ~st_q.busy;
    assign kill = cancel_i & st_q.busy;
    assign hit  = ret_tag_i & st_q.busy & ~cancel_i;

    fanio_rr_pick #(.N(N_RS)) i_pick (
        .elig_i (elig),
        .ptr_i  (st_q.rr),
        .grant_o(grant),
        .win_o  (win)
    );

    fanio_fanin #(.N(N_RS), .OPW(OPW), .MW(MW)) i_fanin (
        .grant_i(grant),
        .data_i (req_data_i),
        .mask_i (req_mask_i),
        .data_o (sel_data),
        .mask_o (sel_mask)
    );

    fanio_fanout #(.N(N_RS), .RESW(RESW), .MW(MW)) i_fanout (
        .hit_i     (hit),
        .ret_data_i(ret_data_i),
        .ret_mask_i(ret_mask_i),
        .cur_data_i(st_q.rdata),
        .cur_mask_i(st_q.rmask),
        .nxt_data_o(nxt_rdata),
        .nxt_mask_o(nxt_rmask)
    );

    always_comb begin
        st_d        = st_q;
        st_d.busy   = (st_q.busy & ~hit & ~kill) | grant;
        st_d.pvalid = |grant;
        st_d.ptag   = grant;
        if (|grant) begin
            st_d.rr    = PW'(fanio_pkg::wrap_inc(32'(win), N_RS));
            st_d.pdata = sel_data;
            st_d.pmask = sel_mask;
        end
        st_d.done  = hit;
        st_d.rdata = nxt_rdata;
        st_d.rmask = nxt_rmask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_grant_o   = grant;
    assign busy_o        = st_q.busy;
    assign pipe_valid_o  = st_q.pvalid;
    assign pipe_tag_o    = st_q.ptag;
    assign pipe_data_o   = st_q.pdata;
    assign pipe_mask_o   = st_q.pmask;
    assign pipe_cancel_o = kill;
    assign done_o        = st_q.done;
    assign res_data_o    = st_q.rdata;
    assign res_mask_o    = st_q.rmask;
endmodule

// File: rtl/fanio_router_checker.sv
module fanio_router_checker #(
    parameter int unsigned N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_valid_i,
    input logic [N-1:0] cancel_i,
    input logic [N-1:0] ret_tag_i,
    input logic [N-1:0] req_grant_o,
    input logic [N-1:0] busy_o,
    input logic         pipe_valid_o,
    input logic [N-1:0] pipe_tag_o,
    input logic [N-1:0] pipe_cancel_o,
    input logic [N-1:0] done_o
);
    assert_grant_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant_o));

    assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant_o & ~req_valid_i) == '0);

    assert_grant_to_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant_o != '0) |=> (pipe_valid_o && pipe_tag_o == $past(req_grant_o)));

    assert_tag_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pipe_tag_o));

    assert_no_busy_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant_o & busy_o) == '0);

    assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_o) |-> (req_grant_o == '0));

    assert_done_from_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_tag_i & busy_o & ~cancel_i) != '0 |=> (done_o & $past(ret_tag_i & busy_o & ~cancel_i)) == $past(ret_tag_i & busy_o & ~cancel_i));

    assert_stray_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_tag_i & ~busy_o) != '0 |=> (done_o & $past(ret_tag_i & ~busy_o)) == '0);

    assert_cancel_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i & busy_o) != '0 |=> (busy_o & $past(cancel_i & busy_o)) == '0);

    assert_cancel_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_i & ret_tag_i) != '0 |=> (done_o & $past(cancel_i & ret_tag_i)) == '0);

    assert_idle_cancel_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_cancel_o & ~busy_o) == '0);
endmodule

bind fu_fanio_router fanio_router_checker #(.N(N_RS)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .cancel_i     (cancel_i),
    .ret_tag_i    (ret_tag_i),
    .req_grant_o  (req_grant_o),
    .busy_o       (busy_o),
    .pipe_valid_o (pipe_valid_o),
    .pipe_tag_o   (pipe_tag_o),
    .pipe_cancel_o(pipe_cancel_o),
    .done_o       (done_o)
);

// File: tb/test_fu_fanio_router.sv
module test_fu_fanio_router;
    localparam int N = 3, OPW = 16, RESW = 16, MW = 2, LAT = 4;

    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic [N-1:0]      req_valid, grant, busy, cancel, pcan, ptag, done;
    logic [N*OPW-1:0]  req_data;
    logic [N*MW-1:0]   req_mask, pmask, rmask;
    logic              pvalid;
    logic [OPW-1:0]    pdata;
    logic [N*RESW-1:0] rdata;

    logic              loop_en;
    logic [N-1:0]      tb_ret_tag, ret_tag;
    logic [RESW-1:0]   tb_ret_data, ret_data;
    logic [N*MW-1:0]   tb_ret_mask, ret_mask;

    logic [N-1:0]      dl_tag  [LAT];
    logic [RESW-1:0]   dl_data [LAT];
    logic [N*MW-1:0]   dl_mask [LAT];

    assign ret_tag  = loop_en ? dl_tag[LAT-1]  : tb_ret_tag;
    assign ret_data = loop_en ? dl_data[LAT-1] : tb_ret_data;
    assign ret_mask = loop_en ? dl_mask[LAT-1] : tb_ret_mask;

    // pipeline model: fixed delay, result = operand + 0x100, global cancel drops tags
    always @(posedge clk) begin
        dl_tag[0]  <= pipe_in_tag();
        dl_data[0] <= pdata + 16'h0100;
        dl_mask[0] <= pmask;
        for (int i = 1; i < LAT; i++) begin
            dl_tag[i]  <= dl_tag[i-1] & ~pcan;
            dl_data[i] <= dl_data[i-1];
            dl_mask[i] <= dl_mask[i-1];
        end
    end

    function automatic logic [N-1:0] pipe_in_tag();
        return (pvalid ? ptag : '0) & ~pcan;
    endfunction

    fu_fanio_router #(.N_RS(N), .OPW(OPW), .RESW(RESW), .MW(MW)) i_fu_fanio_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_data_i(req_data), .req_mask_i(req_mask),
        .req_grant_o(grant), .busy_o(busy), .cancel_i(cancel),
        .pipe_valid_o(pvalid), .pipe_tag_o(ptag), .pipe_data_o(pdata),
        .pipe_mask_o(pmask), .pipe_cancel_o(pcan),
        .ret_tag_i(ret_tag), .ret_data_i(ret_data), .ret_mask_i(ret_mask),
        .done_o(done), .res_data_o(rdata), .res_mask_o(rmask)
    );

    int n_checks = 0, n_fail = 0;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // rows: {req, cancel, ret_tag, exp_grant, exp_pcan, exp_done, exp_busy}
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {3'b111, 3'b000, 3'b000, 3'b001, 3'b000, 3'b000, 3'b001}, // R2 R3
        {3'b111, 3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b011}, // R5 busy skipped
        {3'b111, 3'b000, 3'b000, 3'b100, 3'b000, 3'b000, 3'b111},
        {3'b111, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b111}, // R6 stall
        {3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b010, 3'b101}, // R7 return
        {3'b000, 3'b001, 3'b000, 3'b000, 3'b001, 3'b000, 3'b100}, // R9 cancel
        {3'b011, 3'b000, 3'b000, 3'b001, 3'b000, 3'b000, 3'b101}, // R9 reuse, R3 wrap
        {3'b011, 3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b111},
        {3'b000, 3'b111, 3'b100, 3'b000, 3'b111, 3'b000, 3'b000}, // R10
        {3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b000, 3'b000}, // R8 idle tag
        {3'b110, 3'b010, 3'b000, 3'b100, 3'b000, 3'b000, 3'b100}, // R11 idle cancel, R3
        {3'b011, 3'b000, 3'b000, 3'b001, 3'b000, 3'b000, 3'b101},
        {3'b111, 3'b000, 3'b000, 3'b010, 3'b000, 3'b000, 3'b111}
    };

    function automatic logic [N*MW-1:0] mask_field(input logic [N-1:0] g, input logic [N*MW-1:0] src);
        logic [N*MW-1:0] r = '0;
        for (int k = 0; k < N; k++) if (g[k]) r[k*MW +: MW] = src[k*MW +: MW];
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
    end

    int cnt [N];
    logic [RESW-1:0] last [N];
    always @(negedge clk) if (loop_en) begin
        for (int k = 0; k < N; k++) if (done[k]) begin
            cnt[k]++;
            last[k] = rdata[k*RESW +: RESW];
        end
    end

    initial begin
        logic [N-1:0] eg, ep, ed, eb, rq;
        rst_n = 1'b0; loop_en = 1'b0;
        req_valid = '0; cancel = '0; tb_ret_tag = '0; tb_ret_data = '0; tb_ret_mask = '0;
        req_data = {16'hC002, 16'hC001, 16'hC000};
        req_mask = {2'b11, 2'b10, 2'b01};
        for (int k = 0; k < N; k++) begin cnt[k] = 0; last[k] = '0; end
        repeat (3) @(negedge clk);
        check(busy == '0 && pvalid == 1'b0 && done == '0, "R1 reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == '0 && pvalid == 1'b0 && done == '0, "R1 after reset", {busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            rq = VEC[i][20:18];
            req_valid   = rq;
            cancel      = VEC[i][17:15];
            tb_ret_tag  = VEC[i][14:12];
            tb_ret_data = 16'h5A00 + 16'(i);
            tb_ret_mask = 6'h39;
            eg = VEC[i][11:9]; ep = VEC[i][8:6]; ed = VEC[i][5:3]; eb = VEC[i][2:0];
            #1;
            check(grant == eg, "R2 R3 R6 grant", grant, eg);
            check(pcan == ep, "R9 R11 cancel vector", pcan, ep);
            @(posedge clk); @(negedge clk);
            check(busy == eb, "R5 R9 R10 busy", busy, eb);
            check(done == ed, "R7 R8 R10 done", done, ed);
            check(pvalid == (|eg) && ptag == eg, "R2 pipe tag", ptag, eg);
            if (|eg) begin
                for (int k = 0; k < N; k++) if (eg[k])
                    check(pdata == req_data[k*OPW +: OPW], "R2 pipe data", pdata, req_data[k*OPW +: OPW]);
                check(pmask == mask_field(eg, req_mask), "R4 mask concat", pmask, mask_field(eg, req_mask));
            end
            for (int k = 0; k < N; k++) if (ed[k]) begin
                check(rdata[k*RESW +: RESW] == 16'h5A00 + 16'(i), "R7 result latch", rdata[k*RESW +: RESW], 16'h5A00 + 16'(i));
                check(rmask[k*MW +: MW] == tb_ret_mask[k*MW +: MW], "R7 mask split", rmask[k*MW +: MW], tb_ret_mask[k*MW +: MW]);
            end
        end
        req_valid = '0; cancel = '0; tb_ret_tag = '0;

        // closed loop through the delay-line pipeline, cancel while in flight
        rst_n = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        check(busy == '0 && done == '0, "R1 second reset", busy, 0);
        rst_n = 1'b1; loop_en = 1'b1;
        req_valid = 3'b111;
        repeat (3) @(negedge clk);
        req_valid = '0;
        check(busy == 3'b111, "R5 loop busy", busy, 3'b111);
        cancel = 3'b010;
        @(negedge clk);
        cancel = '0;
        check(busy[1] == 1'b0, "R9 in-flight cancel frees", busy, 3'b101);
        req_data[OPW +: OPW] = 16'hD001;
        req_valid = 3'b010;
        #1;
        check(grant == 3'b010, "R9 immediate reuse", grant, 3'b010);
        @(negedge clk);
        req_valid = '0;
        repeat (12) @(negedge clk);
        check(cnt[0] == 1, "R7 loop done st0", cnt[0], 1);
        check(cnt[1] == 1, "R9 cancelled entry dropped", cnt[1], 1);
        check(cnt[2] == 1, "R7 loop done st2", cnt[2], 1);
        check(last[1] == 16'hD101, "R9 reissued result", last[1], 16'hD101);
        check(last[0] == 16'hC100, "R7 tag steering", last[0], 16'hC100);
        check(busy == '0, "R7 all released", busy, 0);
        report();
    end
endmodule